// File: doc/BRIEF.md
# Signed BCD Up/Down Result Counter

This block holds the running result of an integrating converter as a signed-magnitude decimal number. The magnitude has four full BCD digits and a leading half-digit that can only be 0 or 1, so the span is -19999 to +19999 counts. A phase sequencer drives it with single-cycle commands: step the signed value up or down by one, multiply it by ten between a coarse and a fine measuring phase, or clear it at the start of a conversion. When a step reaches zero and keeps going, the sign follows the step direction and the magnitude counts up from zero again.

The counter raises an overrange flag when the magnitude would pass 19999, and then holds its value until it is cleared. A live underrange flag marks magnitudes below 1000. A display register set captures digits, sign and both flags when the active-low latch strobe falls, and keeps them until the next fall. A show-live input lets the display outputs follow the running counter, for instance while the count is being built up. The range flags on the display side always come from the captured copy.

Top module: `signed_bcd_counter`

## Requirements
- R1: Reset, and a `clr` command on any clock, set every live digit and the half-digit to 0, the sign to positive (0) and the overrange flag to 0 on the next clock. Reset also sets all display registers and display flags to 0.
- R2: `live_digits` and `disp_digits` hold one BCD digit per nibble, nibble 0 (bits 3:0) the units and nibble 3 the thousands. The half-digit output gives the ten-thousands (0 or 1). No nibble ever holds a value above 9.
- R3: With `cnt_up` alone the signed value goes up by one on the next clock, and with `cnt_dn` alone it goes down by one. With both high or both low the value holds.
- R4: A step from magnitude zero gives magnitude 1, with the sign set by the step direction (1 = negative for a down step). A step toward zero from magnitude 1 gives magnitude 0 and leaves the sign as it was.
- R5: `x10` multiplies the magnitude by ten: every digit moves up one place, the thousands digit moves into the half-digit and the units become 0. The sign is kept. If the magnitude is 2000 or more, the overrange flag is set instead and the magnitude is left as it was.
- R6: A step away from zero at magnitude 19999 sets the overrange flag and leaves the magnitude at 19999. While the flag is set, steps and `x10` are ignored until `clr`.
- R7: `live_under` is 1 exactly when overrange is 0 and the magnitude is below 1000.
- R8: Priority on a clock where several commands are high: `clr` first, then `x10`, then steps.
- R9: On the clock edge where `latch_n` is sampled low after being sampled high, the display registers take the live digits, half-digit, sign, overrange and underrange as they were before that edge. On every other edge they hold. The first high sample after reset arms the capture.
- R10: While `show_live` is 1, `disp_digits`, `disp_half` and `disp_sign` show the live counter in the same cycle. `disp_over` and `disp_under` always show the captured flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clear the counter |
| cnt_up | input | 1 | Step the signed value up by one |
| cnt_dn | input | 1 | Step the signed value down by one |
| x10 | input | 1 | Multiply the magnitude by ten |
| latch_n | input | 1 | Active-low capture strobe; capture on its fall |
| show_live | input | 1 | Route the live counter to the display digits |
| live_digits | output | 4*NDIG | Live BCD magnitude digits |
| live_half | output | 1 | Live leading half-digit |
| live_sign | output | 1 | Live sign, 1 = negative |
| live_over | output | 1 | Live overrange flag |
| live_under | output | 1 | Live underrange flag |
| disp_digits | output | 4*NDIG | Display digits (captured or live) |
| disp_half | output | 1 | Display half-digit |
| disp_sign | output | 1 | Display sign |
| disp_over | output | 1 | Captured overrange flag |
| disp_under | output | 1 | Captured underrange flag |

## Verification
The bench targets the zero crossing in both directions. A design that decremented a zero magnitude would show 9999 with the wrong sign, and one that cleared the sign at zero would lose the negative zero that follows stepping up from -1. It drives the counter to 19999 and to 2000 and then steps and multiplies. A wrong saturation would wrap to zero or let `x10` corrupt the half-digit. Commands that arrive together check the priority order, and latch strobes placed at random check that a capture takes the value from before the edge and that the display flags stay frozen while `show_live` moves the digits.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    localparam int CTR_DIGITS = 4;

    typedef logic [3:0] bcd_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CLEAR,
        OP_SHIFT,
        OP_PRESET,
        OP_STEP,
        OP_SATURATE
    } ctr_op_t;

    typedef struct packed {
        logic sign;
        logic half;
        logic over;
        logic under;
    } ctr_flags_t;

    function automatic bcd_t bcd_succ(input bcd_t d);
        return (d == 4'd9) ? 4'd0 : d + 4'd1;
    endfunction

    function automatic bcd_t bcd_pred(input bcd_t d);
        return (d == 4'd0) ? 4'd9 : d - 4'd1;
    endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import ctr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic preset,
    input  logic shift_en,
    input  bcd_t shift_in,
    input  logic step_in,
    input  logic inc,
    output bcd_t d_q,
    output logic step_out
);

    // A carry (counting up) or borrow (counting down) passes on at the digit's limit.
    always_comb begin
        step_out = step_in & (inc ? (d_q == 4'd9) : (d_q == 4'd0));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            d_q <= 4'd0;
        end else if (preset) begin
            d_q <= 4'd1;
        end else if (shift_en) begin
            d_q <= shift_in;
        end else if (step_in) begin
            d_q <= inc ? bcd_succ(d_q) : bcd_pred(d_q);
        end
    end

endmodule

// File: rtl/sgn_mag_core.sv
module sgn_mag_core
    import ctr_pkg::*;
#(
    parameter int NDIG = CTR_DIGITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cnt_up,
    input  logic              cnt_dn,
    input  logic              x10,
    output logic [4*NDIG-1:0] digits,
    output ctr_flags_t        flags
);

    localparam int TOP = NDIG - 1;

    bcd_t       dig   [NDIG];
    logic [NDIG:0] chain;
    logic [NDIG-1:0] is_zero;
    logic [NDIG-1:0] is_nine;

    logic    half_q, sign_q, over_q;
    logic    mag_zero, mag_full, away;
    ctr_op_t op;

    // Operation decode, in priority order: clear, multiply, step.
    always_comb begin
        away = (cnt_dn == sign_q);
        op   = OP_IDLE;
        if (clr) begin
            op = OP_CLEAR;
        end else if (over_q) begin
            op = OP_IDLE;
        end else if (x10) begin
            op = (half_q || (dig[TOP] > 4'd1)) ? OP_SATURATE : OP_SHIFT;
        end else if (cnt_up ^ cnt_dn) begin
            if (mag_zero)
                op = OP_PRESET;
            else if (away && mag_full)
                op = OP_SATURATE;
            else
                op = OP_STEP;
        end
    end

    assign chain[0] = (op == OP_STEP);

    genvar gi;
    generate
        for (gi = 0; gi < NDIG; gi++) begin : g_dig
            bcd_t sh_in;
            if (gi == 0) begin : g_lsd
                assign sh_in = 4'd0;
            end else begin : g_up
                assign sh_in = dig[gi-1];
            end

            bcd_digit_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .clr      (op == OP_CLEAR),
                .preset   ((gi == 0) && (op == OP_PRESET)),
                .shift_en (op == OP_SHIFT),
                .shift_in (sh_in),
                .step_in  (chain[gi]),
                .inc      (away),
                .d_q      (dig[gi]),
                .step_out (chain[gi+1])
            );

            assign is_zero[gi]        = (dig[gi] == 4'd0);
            assign is_nine[gi]        = (dig[gi] == 4'd9);
            assign digits[4*gi +: 4]  = dig[gi];
        end
    endgenerate

    assign mag_zero = (&is_zero) & ~half_q;
    assign mag_full = (&is_nine) & half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
            sign_q <= 1'b0;
            over_q <= 1'b0;
        end else begin
            unique case (op)
                OP_CLEAR: begin
                    half_q <= 1'b0;
                    sign_q <= 1'b0;
                    over_q <= 1'b0;
                end
                OP_SHIFT:    half_q <= dig[TOP][0];
                OP_PRESET:   sign_q <= cnt_dn;
                OP_STEP:     if (chain[NDIG]) half_q <= ~half_q;
                OP_SATURATE: over_q <= 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        flags.sign  = sign_q;
        flags.half  = half_q;
        flags.over  = over_q;
        flags.under = ~over_q & ~half_q & (dig[TOP] == 4'd0);
    end

endmodule

// File: rtl/disp_capture.sv
module disp_capture
    import ctr_pkg::*;
#(
    parameter int NDIG = CTR_DIGITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_n,
    input  logic [4*NDIG-1:0] live_digits,
    input  ctr_flags_t        live_flags,
    output logic [4*NDIG-1:0] held_digits,
    output ctr_flags_t        held_flags
);

    logic strobe_prev;
    logic capture;

    assign capture = strobe_prev & ~latch_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_prev <= 1'b0;
            held_digits <= '0;
            held_flags  <= '0;
        end else begin
            strobe_prev <= latch_n;
            if (capture) begin
                held_digits <= live_digits;
                held_flags  <= live_flags;
            end
        end
    end

endmodule

// File: rtl/signed_bcd_counter.sv
module signed_bcd_counter
    import ctr_pkg::*;
#(
    parameter int NDIG = CTR_DIGITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cnt_up,
    input  logic              cnt_dn,
    input  logic              x10,
    input  logic              latch_n,
    input  logic              show_live,
    output logic [4*NDIG-1:0] live_digits,
    output logic              live_half,
    output logic              live_sign,
    output logic              live_over,
    output logic              live_under,
    output logic [4*NDIG-1:0] disp_digits,
    output logic              disp_half,
    output logic              disp_sign,
    output logic              disp_over,
    output logic              disp_under
);

    ctr_flags_t        cur_f;
    ctr_flags_t        hold_f;
    logic [4*NDIG-1:0] hold_d;

    sgn_mag_core #(.NDIG(NDIG)) u_core (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .cnt_up (cnt_up),
        .cnt_dn (cnt_dn),
        .x10    (x10),
        .digits (live_digits),
        .flags  (cur_f)
    );

    disp_capture #(.NDIG(NDIG)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .latch_n     (latch_n),
        .live_digits (live_digits),
        .live_flags  (cur_f),
        .held_digits (hold_d),
        .held_flags  (hold_f)
    );

    assign live_half  = cur_f.half;
    assign live_sign  = cur_f.sign;
    assign live_over  = cur_f.over;
    assign live_under = cur_f.under;

    assign disp_digits = show_live ? live_digits : hold_d;
    assign disp_half   = show_live ? cur_f.half  : hold_f.half;
    assign disp_sign   = show_live ? cur_f.sign  : hold_f.sign;
    assign disp_over   = hold_f.over;
    assign disp_under  = hold_f.under;

endmodule

// File: rtl/signed_bcd_counter_chk.sv
module signed_bcd_counter_chk #(
    parameter int NDIG = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              cnt_up,
    input logic              cnt_dn,
    input logic              x10,
    input logic              latch_n,
    input logic              show_live,
    input logic [4*NDIG-1:0] live_digits,
    input logic              live_half,
    input logic              live_sign,
    input logic              live_over,
    input logic              live_under,
    input logic [4*NDIG-1:0] disp_digits,
    input logic              disp_half,
    input logic              disp_sign,
    input logic              disp_over,
    input logic              disp_under
);

    function automatic logic all_bcd(input logic [4*NDIG-1:0] v);
        for (int i = 0; i < NDIG; i++)
            if (v[4*i +: 4] > 4'd9) return 1'b0;
        return 1'b1;
    endfunction

    // R2: every nibble is a decimal digit
    a_r2_bcd_digits: assert property (@(posedge clk) disable iff (rst)
        all_bcd(live_digits) && all_bcd(disp_digits));

    // R1: clear empties the counter
    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (live_digits == '0) && !live_half && !live_sign && !live_over);

    // R6: overrange holds the value until clear
    a_r6_over_sticky: assert property (@(posedge clk) disable iff (rst)
        (live_over && !clr) |=> live_over && $stable(live_digits) && $stable(live_half));

    // R4: leaving zero gives magnitude one with the step's sign
    a_r4_leave_zero: assert property (@(posedge clk) disable iff (rst)
        ((live_digits == '0) && !live_half && !live_over && !clr && !x10 && (cnt_up ^ cnt_dn))
        |=> (live_digits == (4*NDIG)'(1)) && !live_half && (live_sign == $past(cnt_dn)));

    // R9: captured flags move only after a strobe fall
    a_r9_hold_flags: assert property (@(posedge clk) disable iff (rst)
        !$fell(latch_n) |=> $stable(disp_over) && $stable(disp_under));

    // R7: underrange and overrange never together
    a_r7_under_excl: assert property (@(posedge clk) disable iff (rst)
        live_under |-> !live_over);

endmodule

bind signed_bcd_counter signed_bcd_counter_chk #(.NDIG(NDIG)) u_chk (.*);

// File: tb/signed_bcd_counter_tb.sv
module signed_bcd_counter_tb;

    localparam int NDIG = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0, cnt_up = 1'b0, cnt_dn = 1'b0, x10 = 1'b0;
    logic latch_n = 1'b1, show_live = 1'b0;
    logic [4*NDIG-1:0] live_digits, disp_digits;
    logic live_half, live_sign, live_over, live_under;
    logic disp_half, disp_sign, disp_over, disp_under;

    always #4 clk = ~clk;

    signed_bcd_counter #(.NDIG(NDIG)) u_dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference state
    int m_mag = 0;
    bit m_sign = 0, m_over = 0, m_prev_l = 0;
    int c_mag = 0;
    bit c_sign = 0, c_over = 0, c_under = 0;

    function automatic logic [15:0] to_bcd(input int mag);
        logic [15:0] r;
        int v = mag % 10000;
        for (int i = 0; i < 4; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    function automatic bit under_of(input int mag, input bit ov);
        return !ov && (mag < 1000);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit c, input bit u, input bit d, input bit x, input bit l);
        if (m_prev_l && !l) begin
            c_mag = m_mag; c_sign = m_sign; c_over = m_over;
            c_under = under_of(m_mag, m_over);
        end
        m_prev_l = l;
        if (c) begin
            m_mag = 0; m_sign = 0; m_over = 0;
        end else if (m_over) begin
        end else if (x) begin
            if (m_mag >= 2000) m_over = 1;
            else m_mag = m_mag * 10;
        end else if (u ^ d) begin
            if (m_mag == 0) begin
                m_sign = d; m_mag = 1;
            end else if (d == m_sign) begin
                if (m_mag == 19999) m_over = 1;
                else m_mag++;
            end else begin
                m_mag--;
            end
        end
    endtask

    task automatic cyc(input bit c, input bit u, input bit d, input bit x,
                       input bit l, input bit s, input string tag);
        clr = c; cnt_up = u; cnt_dn = d; x10 = x; latch_n = l; show_live = s;
        model_step(c, u, d, x, l);
        @(posedge clk); #1;
        chk({tag, " R2 R3 live digits"}, int'(live_digits), int'(to_bcd(m_mag)));
        chk({tag, " R2 live half"}, int'(live_half), int'(m_mag >= 10000));
        chk({tag, " R4 live sign"}, int'(live_sign), int'(m_sign));
        chk({tag, " R6 live over"}, int'(live_over), int'(m_over));
        chk({tag, " R7 live under"}, int'(live_under), int'(under_of(m_mag, m_over)));
        chk({tag, " R9 R10 disp digits"}, int'(disp_digits), int'(to_bcd(s ? m_mag : c_mag)));
        chk({tag, " R10 disp half"}, int'(disp_half), int'(s ? (m_mag >= 10000) : (c_mag >= 10000)));
        chk({tag, " R10 disp sign"}, int'(disp_sign), int'(s ? m_sign : c_sign));
        chk({tag, " R9 disp over"}, int'(disp_over), int'(c_over));
        chk({tag, " R9 disp under"}, int'(disp_under), int'(c_under));
    endtask

    task automatic ups(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 1, 0, tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c0de));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk("R1 reset digits", int'(live_digits), 0);
        chk("R1 reset sign", int'(live_sign), 0);
        chk("R1 reset over", int'(live_over), 0);
        chk("R1 reset disp", int'({disp_digits, disp_half, disp_sign, disp_over, disp_under}), 0);
        chk("R7 reset under", int'(live_under), 1);

        // R4 zero crossing
        cyc(0, 0, 1, 0, 1, 0, "R4 down from zero");
        chk("R4 negative one sign", int'(live_sign), 1);
        cyc(0, 1, 0, 0, 1, 0, "R4 up to negative zero");
        chk("R4 zero keeps sign", int'(live_sign), 1);
        cyc(0, 1, 0, 0, 1, 0, "R4 up from negative zero");
        chk("R4 plus one", int'(live_digits), 1);
        // R3 both and neither
        cyc(0, 1, 1, 0, 1, 0, "R3 both held");
        cyc(0, 0, 0, 0, 1, 0, "R3 neither held");
        // R5 / R8
        cyc(0, 0, 0, 1, 1, 0, "R5 x10 of one");
        chk("R5 ten", int'(live_digits), 16'h0010);
        cyc(0, 1, 0, 1, 1, 0, "R8 x10 beats step");
        chk("R8 hundred", int'(live_digits), 16'h0100);
        cyc(1, 1, 0, 1, 1, 0, "R8 clr beats all");
        chk("R1 R8 cleared", int'(live_digits), 0);
        // R6 saturation at 19999
        ups(1999, "R3 ramp");
        cyc(0, 0, 0, 1, 1, 0, "R5 x10 into half digit");
        chk("R5 half after shift", int'(live_half), 1);
        ups(9, "R3 top");
        cyc(0, 1, 0, 0, 1, 0, "R6 step past top");
        chk("R6 over set", int'(live_over), 1);
        chk("R6 held at top", int'(live_digits), 16'h9999);
        cyc(0, 0, 1, 0, 1, 0, "R6 down ignored");
        cyc(0, 0, 0, 1, 1, 0, "R6 x10 ignored");
        cyc(0, 0, 0, 0, 0, 0, "R9 capture over");
        chk("R9 captured over", int'(disp_over), 1);
        cyc(1, 0, 0, 0, 1, 0, "R1 clear over");
        // R5 overflow at 2000
        ups(2, "R3 two");
        cyc(0, 0, 0, 1, 1, 0, "R5 20");
        cyc(0, 0, 0, 1, 1, 0, "R5 200");
        cyc(0, 0, 0, 1, 1, 0, "R5 2000");
        cyc(0, 0, 0, 1, 1, 0, "R5 2000 times ten overflows");
        chk("R5 over at 2000", int'(live_over), 1);
        chk("R5 magnitude kept", int'(live_digits), 16'h2000);
        cyc(1, 0, 0, 0, 1, 0, "R1 clear");
        // R9 / R10 capture then live view
        ups(5, "R3 five");
        cyc(0, 0, 0, 0, 0, 0, "R9 capture five");
        ups(3, "R9 hold");
        chk("R9 held five", int'(disp_digits), 5);
        cyc(0, 1, 0, 0, 1, 1, "R10 show live");
        chk("R10 live nine", int'(disp_digits), 9);

        // random mix
        for (int i = 0; i < 6000; i++) begin
            int r = int'($urandom % 1000);
            cyc(r < 4, bit'($urandom % 2), bit'($urandom % 2), (r >= 4) && (r < 30),
                ($urandom % 6) != 0, ($urandom % 4) == 0, "random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule